// File: doc/BRIEF.md
# Two-Colour Hardware Cursor Overlay

This block draws a small hardware cursor on top of a raster stream of display pixels. Each incoming pixel arrives with its screen coordinates and its underlying 24-bit RGB value. The block decides whether the pixel falls inside the cursor window, looks up the cursor's two image bits for that spot, and emits the final colour two cycles later. The coordinates and the valid flag travel with the pixel.

Software programs the block through a small write-only register port and a byte-wide image port. The register port sets the two cursor colours, the cursor size, a signed screen position and an enable flag. The image port fills internal storage that holds two 1-bit-per-pixel planes: a colour plane and a mask plane. Every pixel of the cursor takes its result from its bit pair. It is then transparent, inverting, background-coloured or foreground-coloured.

Register writes land in a pending copy. The copy in use is updated only when the first pixel of a frame arrives, so a cursor move never tears a frame.

Top module: `cursor_overlay`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `out_valid` is 0 and `out_rgb` is 0. After reset both the pending and the active settings are cleared, so the cursor is hidden, its size is unset and its position is (0,0).
- R2: A pixel presented with `pix_valid` high appears on `out_valid`, `out_x` and `out_y` exactly two clock edges later. Pixels presented back to back come out back to back.
- R3: While the active enable flag (bit 0 of the register at select 4) is 0, `out_rgb` equals the input RGB of the same pixel.
- R4: Inside the cursor window, a pixel whose mask bit is 0 outputs the background colour (select 1) when its colour bit is 0. It outputs the foreground colour (select 0) when its colour bit is 1. Both colour registers take red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R5: Inside the window, a pixel whose mask bit is 1 passes the input RGB through unchanged when its colour bit is 0. When its colour bit is 1, it outputs the bitwise complement of each 8-bit input channel.
- R6: A value of 1 written to the size register (select 2) selects a 32x32 cursor and a value of 2 selects a 64x64 cursor. Any other value hides the cursor.
- R7: The position register (select 3) holds a signed 16-bit x in bits 15:0 and a signed 16-bit y in bits 31:16. The screen pixel (x,y) falls in the cursor when 0 <= x-px < size and 0 <= y-py < size, so it uses cursor column x-px and row y-py. Pixels outside the window pass through, and a negative position clips the cursor at the screen edge.
- R8: Image writes are decoded with the pending size. P is 128 bytes for 32x32 and 512 bytes for 64x64. Addresses 0..P-1 hold the colour plane and P..2P-1 hold the mask plane. Each row takes size/8 consecutive bytes, rows are stored in order, and bit 7 of a byte is the leftmost of its eight pixels. Writes at or above 2P, or while the pending size is invalid, are ignored.
- R9: Register writes do not change how pixels are drawn until a valid pixel at (0,0) arrives. That pixel and every pixel after it use the new settings.
- R10: A register write in the same cycle as the (0,0) pixel is not applied to that frame. It takes effect at the following frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0 foreground, 1 background, 2 size, 3 position, 4 control |
| cfg_wdata | input | 32 | Register write data |
| img_we | input | 1 | Image byte write strobe |
| img_addr | input | 10 | Image byte address |
| img_data | input | 8 | Image byte, bit 7 is the leftmost pixel |
| pix_valid | input | 1 | Input pixel valid |
| pix_x | input | 16 | Input pixel column |
| pix_y | input | 16 | Input pixel row |
| pix_rgb | input | 24 | Underlying pixel colour, red in 23:16 |
| out_valid | output | 1 | Output pixel valid |
| out_x | output | 16 | Output pixel column |
| out_y | output | 16 | Output pixel row |
| out_rgb | output | 24 | Composited pixel colour |

## Verification
A register write can occur in the same cycle as the frame-start pixel that commits the pending settings. The bench provokes this by sending a position write together with the (0,0) pixel. It then scans pixels at both the old and the new location. The cursor must stay at its old place for that whole frame and move only at the next (0,0) pixel. The bench also sends pixels between a register write and the next frame start, and they must still be drawn with the old settings.

// File: rtl/cursor_pkg.sv
// Package: shared types and constants for the cursor overlay.
// Assumes 8-bit colour channels and 16-bit screen coordinates.
package cursor_pkg;

    localparam int CH_W   = 8;
    localparam int RGB_W  = 3 * CH_W;
    localparam int POS_W  = 16;
    localparam int CFG_W  = 32;
    localparam int SEL_W  = 3;

    // Register selects
    localparam logic [SEL_W-1:0] SEL_FG   = 3'd0;
    localparam logic [SEL_W-1:0] SEL_BG   = 3'd1;
    localparam logic [SEL_W-1:0] SEL_SIZE = 3'd2;
    localparam logic [SEL_W-1:0] SEL_POS  = 3'd3;
    localparam logic [SEL_W-1:0] SEL_CTRL = 3'd4;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb_t;

    typedef enum logic [1:0] {
        SZ_OFF   = 2'd0,
        SZ_SMALL = 2'd1,
        SZ_LARGE = 2'd2
    } size_e;

    // Encoding is {mask bit, colour bit}
    typedef enum logic [1:0] {
        PK_BACK   = 2'b00,
        PK_FORE   = 2'b01,
        PK_CLEAR  = 2'b10,
        PK_INVERT = 2'b11
    } pix_kind_e;

    typedef struct packed {
        rgb_t                    fg;
        rgb_t                    bg;
        size_e                   size;
        logic signed [POS_W-1:0] pos_x;
        logic signed [POS_W-1:0] pos_y;
        logic                    vis;
    } cfg_t;

    // Map a raw size word to a size code; anything but 1 or 2 hides the cursor
    function automatic size_e size_decode(input logic [CFG_W-1:0] v);
        if (v == CFG_W'(1))      return SZ_SMALL;
        else if (v == CFG_W'(2)) return SZ_LARGE;
        else                     return SZ_OFF;
    endfunction

endpackage

// File: rtl/cursor_cfg.sv
// Module: cursor_cfg
// Holds the pending register copy written by software and the active copy
// used for drawing. The active copy loads from the pending one on commit.
// Assumes commit is a single-cycle pulse on the first pixel of a frame.
// eff is the setting seen by the pixel of the current cycle.
module cursor_cfg
    import cursor_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             commit,
    output cfg_t             pend_q,
    output cfg_t             act_q,
    output cfg_t             eff
);

    // Pending copy: take software writes field by field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (cfg_we) begin
            case (cfg_sel)
                SEL_FG:   pend_q.fg   <= rgb_t'(cfg_wdata[RGB_W-1:0]);
                SEL_BG:   pend_q.bg   <= rgb_t'(cfg_wdata[RGB_W-1:0]);
                SEL_SIZE: pend_q.size <= size_decode(cfg_wdata);
                SEL_POS: begin
                    pend_q.pos_x <= cfg_wdata[POS_W-1:0];
                    pend_q.pos_y <= cfg_wdata[2*POS_W-1:POS_W];
                end
                SEL_CTRL: pend_q.vis  <= cfg_wdata[0];
                default:  ;
            endcase
        end
    end

    // Active copy: load the pending copy (as it was before this cycle's write) at frame start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
        end else if (commit) begin
            act_q <= pend_q;
        end
    end

    // The frame-start pixel itself already uses the settings being committed
    assign eff = commit ? pend_q : act_q;

endmodule

// File: rtl/cursor_image.sv
// Module: cursor_image
// Stores the colour plane and the mask plane as DIM_L x DIM_L bit grids.
// Byte writes are decoded with the pending size: the colour plane comes first,
// the mask plane follows it, rows are packed, and bit 7 is the leftmost pixel.
// A small cursor uses the upper-left DIM_S x DIM_S corner of each grid.
// Reads are combinational; a write becomes visible after the clock edge.
module cursor_image
    import cursor_pkg::*;
#(
    parameter  int DIM_S  = 32,
    parameter  int DIM_L  = 64,
    localparam int BYTES_S = DIM_S / 8,
    localparam int BYTES_L = DIM_L / 8,
    localparam int PLANE_S = DIM_S * BYTES_S,
    localparam int PLANE_L = DIM_L * BYTES_L,
    localparam int ADDR_W  = $clog2(2 * PLANE_L),
    localparam int RC_W    = $clog2(DIM_L),
    localparam int LANE_W  = $clog2(BYTES_L)
)(
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CH_W-1:0]   wr_data,
    input  size_e             wr_size,
    input  logic [RC_W-1:0]   rd_row,
    input  logic [RC_W-1:0]   rd_col,
    output logic [1:0]        rd_bits
);

    logic              wr_ok;
    logic              wr_plane;
    logic [ADDR_W-1:0] wr_off;
    logic [RC_W-1:0]   wr_row;
    logic [LANE_W-1:0] wr_lane;
    logic [RC_W-1:0]   wr_base;
    logic [RC_W-1:0]   rd_bit;

    // Split a byte address into plane, row and byte lane for the pending size
    always_comb begin
        wr_ok    = 1'b0;
        wr_plane = 1'b0;
        wr_off   = '0;
        wr_row   = '0;
        wr_lane  = '0;
        case (wr_size)
            SZ_SMALL: begin
                wr_ok    = (wr_addr < ADDR_W'(2 * PLANE_S));
                wr_plane = (wr_addr >= ADDR_W'(PLANE_S));
                wr_off   = wr_plane ? (wr_addr - ADDR_W'(PLANE_S)) : wr_addr;
                wr_row   = RC_W'(wr_off / ADDR_W'(BYTES_S));
                wr_lane  = LANE_W'(wr_off % ADDR_W'(BYTES_S));
            end
            SZ_LARGE: begin
                wr_ok    = 1'b1;
                wr_plane = (wr_addr >= ADDR_W'(PLANE_L));
                wr_off   = wr_plane ? (wr_addr - ADDR_W'(PLANE_L)) : wr_addr;
                wr_row   = RC_W'(wr_off / ADDR_W'(BYTES_L));
                wr_lane  = LANE_W'(wr_off % ADDR_W'(BYTES_L));
            end
            default: ;
        endcase
    end

    // Lane 0 lands in the top byte of the row word, so column 0 is bit DIM_L-1
    assign wr_base = RC_W'((BYTES_L - 1 - int'(wr_lane)) * 8);
    assign rd_bit  = RC_W'(DIM_L - 1) - rd_col;

    for (genvar p = 0; p < 2; p++) begin : g_plane
        logic [DIM_L-1:0] grid [DIM_L];

        // Byte write into this plane's grid
        always_ff @(posedge clk) begin
            if (wr_en && wr_ok && (wr_plane == 1'(p))) begin
                grid[wr_row][wr_base +: 8] <= wr_data;
            end
        end

        assign rd_bits[p] = grid[rd_row][rd_bit];
    end

endmodule

// File: rtl/cursor_hit.sv
// Module: cursor_hit
// Decides whether a screen pixel lies inside the cursor window and gives
// the cursor row and column it maps to. The position is signed, so the
// window may be partly or wholly off screen. A hidden size never hits.
module cursor_hit
    import cursor_pkg::*;
#(
    parameter  int DIM_S = 32,
    parameter  int DIM_L = 64,
    localparam int D_W   = POS_W + 2,
    localparam int RC_W  = $clog2(DIM_L)
)(
    input  logic [POS_W-1:0]        pix_x,
    input  logic [POS_W-1:0]        pix_y,
    input  logic signed [POS_W-1:0] pos_x,
    input  logic signed [POS_W-1:0] pos_y,
    input  size_e                   size,
    output logic                    hit,
    output logic [RC_W-1:0]         row,
    output logic [RC_W-1:0]         col
);

    logic signed [D_W-1:0] dx;
    logic signed [D_W-1:0] dy;
    logic [D_W-1:0]        dim;
    logic                  in_x;
    logic                  in_y;

    // Offsets from the cursor origin, wide enough for any signed difference
    assign dx = $signed({2'b00, pix_x}) - $signed({{2{pos_x[POS_W-1]}}, pos_x});
    assign dy = $signed({2'b00, pix_y}) - $signed({{2{pos_y[POS_W-1]}}, pos_y});

    assign dim  = (size == SZ_LARGE) ? D_W'(DIM_L) : D_W'(DIM_S);
    assign in_x = !dx[D_W-1] && (D_W'(dx) < dim);
    assign in_y = !dy[D_W-1] && (D_W'(dy) < dim);
    assign hit  = in_x && in_y && (size != SZ_OFF);
    assign col  = dx[RC_W-1:0];
    assign row  = dy[RC_W-1:0];

endmodule

// File: rtl/cursor_mix.sv
// Module: cursor_mix
// Combines the underlying pixel with the decoded cursor bit pair.
// When draw is low the underlying pixel passes unchanged.
module cursor_mix
    import cursor_pkg::*;
(
    input  logic      draw,
    input  pix_kind_e kind,
    input  rgb_t      under,
    input  rgb_t      fg,
    input  rgb_t      bg,
    output rgb_t      res
);

    // Choose the result by the {mask, colour} pair
    always_comb begin
        res = under;
        if (draw) begin
            case (kind)
                PK_BACK:   res = bg;
                PK_FORE:   res = fg;
                PK_CLEAR:  res = under;
                PK_INVERT: res = ~under;
                default:   res = under;
            endcase
        end
    end

endmodule

// File: rtl/cursor_overlay.sv
// Module: cursor_overlay (top)
// Two-stage pipeline that draws a two-colour cursor over a raster stream.
// Stage 1 registers the window test, the image bits and the colours in use.
// Stage 2 registers the composited colour. Valid and coordinates follow both stages.
// Assumes the first pixel of each frame arrives at (0,0); it commits the
// pending settings, which also apply to that pixel.
module cursor_overlay
    import cursor_pkg::*;
#(
    parameter  int DIM_S  = 32,
    parameter  int DIM_L  = 64,
    localparam int ADDR_W = $clog2(2 * DIM_L * DIM_L / 8),
    localparam int RC_W   = $clog2(DIM_L)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              img_we,
    input  logic [ADDR_W-1:0] img_addr,
    input  logic [CH_W-1:0]   img_data,
    input  logic              pix_valid,
    input  logic [POS_W-1:0]  pix_x,
    input  logic [POS_W-1:0]  pix_y,
    input  logic [RGB_W-1:0]  pix_rgb,
    output logic              out_valid,
    output logic [POS_W-1:0]  out_x,
    output logic [POS_W-1:0]  out_y,
    output logic [RGB_W-1:0]  out_rgb
);

    logic             frame_start;
    cfg_t             pend_q;
    cfg_t             act_q;
    cfg_t             eff;
    logic             eff_vis;
    logic             eff_size_ok;
    logic             hit;
    logic [RC_W-1:0]  cur_row;
    logic [RC_W-1:0]  cur_col;
    logic [1:0]       img_bits;

    // Stage 1 state
    logic             s1_valid;
    logic [POS_W-1:0] s1_x;
    logic [POS_W-1:0] s1_y;
    rgb_t             s1_rgb;
    logic             s1_draw;
    pix_kind_e        s1_kind;
    rgb_t             s1_fg;
    rgb_t             s1_bg;
    rgb_t             mix_rgb;

    assign frame_start = pix_valid && (pix_x == '0) && (pix_y == '0);
    assign eff_vis     = eff.vis;
    assign eff_size_ok = (eff.size != SZ_OFF);

    cursor_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .commit    (frame_start),
        .pend_q    (pend_q),
        .act_q     (act_q),
        .eff       (eff)
    );

    cursor_hit #(.DIM_S(DIM_S), .DIM_L(DIM_L)) u_hit (
        .pix_x (pix_x),
        .pix_y (pix_y),
        .pos_x (eff.pos_x),
        .pos_y (eff.pos_y),
        .size  (eff.size),
        .hit   (hit),
        .row   (cur_row),
        .col   (cur_col)
    );

    cursor_image #(.DIM_S(DIM_S), .DIM_L(DIM_L)) u_img (
        .clk     (clk),
        .wr_en   (img_we),
        .wr_addr (img_addr),
        .wr_data (img_data),
        .wr_size (pend_q.size),
        .rd_row  (cur_row),
        .rd_col  (cur_col),
        .rd_bits (img_bits)
    );

    // Stage 1: capture the pixel, its window decision, image bits and colours
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_x     <= '0;
            s1_y     <= '0;
            s1_rgb   <= '0;
            s1_draw  <= 1'b0;
            s1_kind  <= PK_CLEAR;
            s1_fg    <= '0;
            s1_bg    <= '0;
        end else begin
            s1_valid <= pix_valid;
            s1_x     <= pix_x;
            s1_y     <= pix_y;
            s1_rgb   <= rgb_t'(pix_rgb);
            s1_draw  <= hit && eff.vis;
            s1_kind  <= pix_kind_e'(img_bits);
            s1_fg    <= eff.fg;
            s1_bg    <= eff.bg;
        end
    end

    cursor_mix u_mix (
        .draw  (s1_draw),
        .kind  (s1_kind),
        .under (s1_rgb),
        .fg    (s1_fg),
        .bg    (s1_bg),
        .res   (mix_rgb)
    );

    // Stage 2: register the composited pixel and its sideband
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_x     <= '0;
            out_y     <= '0;
            out_rgb   <= '0;
        end else begin
            out_valid <= s1_valid;
            out_x     <= s1_x;
            out_y     <= s1_y;
            out_rgb   <= mix_rgb;
        end
    end

endmodule

// File: rtl/cursor_overlay_chk.sv
// Module: cursor_overlay_chk
// Property checker bound into cursor_overlay. It relates the input pixel
// stream to the output stream two cycles later, using the settings and
// window decision that the configuration and hit logic present.
module cursor_overlay_chk
    import cursor_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             pix_valid,
    input logic [POS_W-1:0] pix_x,
    input logic [POS_W-1:0] pix_y,
    input logic [RGB_W-1:0] pix_rgb,
    input logic             out_valid,
    input logic [POS_W-1:0] out_x,
    input logic [POS_W-1:0] out_y,
    input logic [RGB_W-1:0] out_rgb,
    input logic             frame_start,
    input logic             eff_vis,
    input logic             eff_size_ok,
    input logic             hit,
    input cfg_t             act_q
);

    // R1: reset leaves no valid pixel on the output
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R2: valid and coordinates reappear two edges later
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> ##1 (out_valid && out_x == $past(pix_x, 2) && out_y == $past(pix_y, 2)));

    // R3: hidden cursor passes the pixel through
    a_r3_hidden_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !eff_vis) |=> ##1 (out_rgb == $past(pix_rgb, 2)));

    // R6: an invalid size passes the pixel through
    a_r6_bad_size_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !eff_size_ok) |=> ##1 (out_rgb == $past(pix_rgb, 2)));

    // R7: a pixel outside the window passes through
    a_r7_outside_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !hit) |=> ##1 (out_rgb == $past(pix_rgb, 2)));

    // R9: active settings only change after a frame-start pixel
    a_r9_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(act_q));

endmodule

bind cursor_overlay cursor_overlay_chk u_chk (.*);

// File: tb/tb_cursor_overlay.sv
// Bench for cursor_overlay: directed phases with random image, colours and
// pixel values from a fixed seed, checked against a bench-side model.
module tb_cursor_overlay;
    import cursor_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [2:0]  cfg_sel;
    logic [31:0] cfg_wdata;
    logic        img_we;
    logic [9:0]  img_addr;
    logic [7:0]  img_data;
    logic        pix_valid;
    logic [15:0] pix_x, pix_y;
    logic [23:0] pix_rgb;
    logic        out_valid;
    logic [15:0] out_x, out_y;
    logic [23:0] out_rgb;

    always #10 clk = ~clk;

    cursor_overlay dut (.*);

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Bench model: pending and active settings, and the two image planes
    logic [23:0] p_fg, p_bg, a_fg, a_bg;
    int          p_size, a_size, p_px, p_py, a_px, a_py;
    bit          p_vis, a_vis;
    bit          grid [0:1][0:63][0:63];

    // Expected output queue
    logic [23:0] q_rgb[$];
    int          q_x[$], q_y[$], q_cyc[$];
    string       q_tag[$];

    function automatic int size_code(input logic [31:0] v);
        if (v == 32'd1) return 32;
        if (v == 32'd2) return 64;
        return 0;
    endfunction

    task automatic fail(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        errors++;
        $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    endtask

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) fail(tag, what, act, exp);
    endtask

    // Expected colour for one pixel from the active model
    task automatic model_pixel(input int x, input int y, input logic [23:0] rgb,
                               output logic [23:0] res, output string tag);
        int dx, dy;
        bit m, c;
        res = rgb;
        if (!a_vis) begin tag = "R3"; return; end
        if (a_size == 0) begin tag = "R6"; return; end
        dx = x - a_px;
        dy = y - a_py;
        if (dx < 0 || dy < 0 || dx >= a_size || dy >= a_size) begin tag = "R7"; return; end
        c = grid[0][dy][dx];
        m = grid[1][dy][dx];
        if (!m) begin res = c ? a_fg : a_bg; tag = "R4"; end
        else begin res = c ? ~rgb : rgb; tag = "R5"; end
    endtask

    task automatic model_commit();
        a_fg = p_fg; a_bg = p_bg; a_size = p_size;
        a_px = p_px; a_py = p_py; a_vis = p_vis;
    endtask

    task automatic model_cfg(input logic [2:0] sel, input logic [31:0] d);
        case (sel)
            3'd0: p_fg = d[23:0];
            3'd1: p_bg = d[23:0];
            3'd2: p_size = size_code(d);
            3'd3: begin p_px = int'($signed(d[15:0])); p_py = int'($signed(d[31:16])); end
            3'd4: p_vis = d[0];
            default: ;
        endcase
    endtask

    // Drive one pixel for one cycle (called at a negedge), optional tag override
    task automatic pix(input int x, input int y, input logic [23:0] rgb, input string tag_o);
        logic [23:0] e;
        string t;
        pix_valid = 1'b1; pix_x = 16'(x); pix_y = 16'(y); pix_rgb = rgb;
        if (x == 0 && y == 0) model_commit();
        model_pixel(x, y, rgb, e, t);
        if (tag_o != "") t = tag_o;
        q_rgb.push_back(e); q_x.push_back(x); q_y.push_back(y);
        q_cyc.push_back(cyc); q_tag.push_back(t);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        pix_valid = 1'b0; cfg_we = 1'b0; img_we = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_wr(input logic [2:0] sel, input logic [31:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        model_cfg(sel, d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // R10: register write in the same cycle as the frame-start pixel
    task automatic frame_with_cfg(input logic [2:0] sel, input logic [31:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        pix_valid = 1'b1; pix_x = '0; pix_y = '0; pix_rgb = $urandom;
        model_commit();
        begin
            logic [23:0] e; string t;
            model_pixel(0, 0, pix_rgb, e, t);
            q_rgb.push_back(e); q_x.push_back(0); q_y.push_back(0);
            q_cyc.push_back(cyc); q_tag.push_back("R10");
        end
        model_cfg(sel, d);
        @(negedge clk);
        cfg_we = 1'b0; pix_valid = 1'b0;
    endtask

    // R8: image byte write with the layout decoded from the pending size
    task automatic img_wr(input int addr, input logic [7:0] d);
        int P, rb, pl, off, row, c0;
        img_we = 1'b1; img_addr = 10'(addr); img_data = d;
        if (p_size != 0) begin
            P = p_size * p_size / 8;
            rb = p_size / 8;
            if (addr < 2 * P) begin
                pl = (addr >= P) ? 1 : 0;
                off = addr - pl * P;
                row = off / rb;
                c0 = (off % rb) * 8;
                for (int i = 0; i < 8; i++) grid[pl][row][c0 + i] = d[7 - i];
            end
        end
        @(negedge clk);
        img_we = 1'b0;
    endtask

    task automatic load_image();
        int P;
        P = p_size * p_size / 8;
        for (int a = 0; a < 2 * P; a++) img_wr(a, 8'($urandom));
    endtask

    task automatic scan(input int x0, input int x1, input int y0, input int y1, input string tag_o);
        for (int y = y0; y <= y1; y++)
            for (int x = x0; x <= x1; x++)
                pix(x, y, 24'($urandom), tag_o);
        idle(1);
    endtask

    task automatic frame();
        pix(0, 0, 24'($urandom), "");
        idle(1);
    endtask

    // Output monitor: compare each valid output against the expected queue
    always @(negedge clk) begin
        if (rst_n === 1'b1 && out_valid === 1'b1) begin
            if (q_rgb.size() == 0) begin
                checks++;
                fail("R2", "unexpected output pixel", {16'(0), out_x}, 32'hFFFF_FFFF);
            end else begin
                logic [23:0] e; int ex, ey, ec; string t;
                e = q_rgb.pop_front(); ex = q_x.pop_front(); ey = q_y.pop_front();
                ec = q_cyc.pop_front(); t = q_tag.pop_front();
                check(t, "pixel colour", {8'h0, out_rgb}, {8'h0, e});
                check("R2", "latency", 32'(cyc - ec), 32'd2);
                check("R2", "coordinates", {out_y, out_x}, {16'(ey), 16'(ex)});
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1789));
        p_fg = '0; p_bg = '0; p_size = 0; p_px = 0; p_py = 0; p_vis = 0;
        model_commit();
        for (int p = 0; p < 2; p++)
            for (int r = 0; r < 64; r++)
                for (int c = 0; c < 64; c++) grid[p][r][c] = 1'b0;
        rst_n = 1'b0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
        img_we = 0; img_addr = 0; img_data = 0;
        pix_valid = 0; pix_x = 0; pix_y = 0; pix_rgb = 0;
        repeat (4) @(negedge clk);
        // R1: outputs idle in reset
        check("R1", "out_valid in reset", {31'b0, out_valid}, 32'd0);
        check("R1", "out_rgb in reset", {8'h0, out_rgb}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "out_valid after reset", {31'b0, out_valid}, 32'd0);

        // R1/R3: cleared settings leave the cursor hidden
        frame();
        scan(0, 40, 0, 3, "R1");

        // Small cursor at (10,5)
        cfg_wr(SEL_FG, 32'($urandom));
        cfg_wr(SEL_BG, 32'($urandom));
        cfg_wr(SEL_SIZE, 32'd1);
        cfg_wr(SEL_POS, {16'd5, 16'd10});
        cfg_wr(SEL_CTRL, 32'd1);
        load_image();
        // R9: still the old (hidden) settings before a frame start
        scan(10, 20, 5, 8, "R9");
        frame();
        scan(6, 45, 2, 40, "");

        // R10: move written with the frame-start pixel waits one frame
        frame_with_cfg(SEL_POS, {16'd30, 16'd40});
        scan(8, 44, 4, 38, "R10");
        frame();
        scan(36, 75, 26, 64, "R10");

        // R8: writes ignored while the pending size is invalid
        cfg_wr(SEL_SIZE, 32'd7);
        for (int a = 0; a < 32; a++) img_wr(a, 8'($urandom));
        for (int a = 128; a < 160; a++) img_wr(a, 8'($urandom));
        cfg_wr(SEL_SIZE, 32'd1);
        // R8: writes beyond both planes are ignored
        for (int a = 256; a < 280; a++) img_wr(a, 8'($urandom));
        frame();
        scan(40, 72, 30, 40, "R8");

        // R6/R7: large cursor partly off screen at a negative position
        cfg_wr(SEL_SIZE, 32'd2);
        load_image();
        cfg_wr(SEL_POS, {-16'sd30, -16'sd20});
        frame();
        scan(0, 50, 0, 40, "");

        // R6: an unsupported size value hides the cursor
        cfg_wr(SEL_SIZE, 32'd3);
        frame();
        scan(0, 30, 0, 20, "R6");

        // R3: enable bit cleared
        cfg_wr(SEL_SIZE, 32'd2);
        cfg_wr(SEL_CTRL, 32'd2);
        frame();
        scan(0, 30, 0, 20, "R3");

        idle(6);
        check("R2", "pixels left unanswered", 32'(q_rgb.size()), 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule